// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address Filter

This block receives asynchronous serial frames on a single line. It runs on the core clock and is advanced by a one-cycle pulse, `tick16`, that arrives sixteen times per bit period. Two frame lengths are supported. The 10-bit frame carries a start bit, eight data bits and a stop bit. The 11-bit frame adds a ninth data bit between the data byte and the stop bit.

The line first passes through a two-flop synchronizer. On each tick the receiver samples the line and starts a frame when it sees a high-to-low transition. Each bit is decided by majority vote over three samples taken around the centre of the bit. A start bit whose vote is high is treated as noise, and the receiver goes back to waiting.

When the frame's last bit is decided, the receiver either delivers the frame or drops it. It delivers the data byte and the extra bit (the stop bit in 10-bit frames, the ninth bit in 11-bit frames) only when its receive flag is clear. When the address filter is enabled, the extra bit must also be 1. This lets a node on a shared line ignore data frames and wake only on address frames. A dropped frame leaves every output untouched.

Top module: `mpc_uart_rx`

## Requirements
- R1: After reset, `rx_flag`, `rx_extra` and `rx_byte` are all 0.
- R2: In idle, a frame starts only when `rx_en` is 1 and the line is sampled 0 on a tick after being sampled 1 on the previous tick. That tick is oversampling state 0. With `rx_en` at 0, a complete frame on the line produces no delivery.
- R3: The value of each bit is the majority of the line samples taken at oversampling states 7, 8 and 9 of that bit. A single wrong sample does not change the received value.
- R4: If the start bit votes 1, the receiver abandons the frame, delivers nothing and returns to idle.
- R5: Data arrives least significant bit first: `rx_byte[i]` is the i-th data bit on the line. `rx_extra` is the bit that follows the eight data bits.
- R6: The outputs and the flag update in the clock cycle after the tick at oversampling state 9 of the tenth bit. That tick is the 153rd tick after the tick that started the frame.
- R7: A frame is delivered only if `rx_flag` is 0 and either `addr_filt_en` is 0 or the extra bit is 1. Otherwise `rx_byte`, `rx_extra` and `rx_flag` keep their values.
- R8: Once set, `rx_flag` stays 1 until a cycle with `flag_clr` high, which clears it.
- R9: With `nine_bit_mode` at 0, the receiver is idle right after the decision. With `nine_bit_mode` at 1, it ignores the line for 16 further ticks after the decision, so a start edge in that window is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | One-cycle pulse, 16 per bit period |
| rx_en | input | 1 | Allows a new frame to start |
| nine_bit_mode | input | 1 | 0: 10-bit frames, 1: 11-bit frames |
| addr_filt_en | input | 1 | Deliver only frames whose extra bit is 1 |
| flag_clr | input | 1 | Clears the receive flag |
| rx_byte | output | 8 | Last delivered data byte |
| rx_extra | output | 1 | Last delivered extra bit |
| rx_flag | output | 1 | Set on delivery, held until cleared |

## Verification
The assertions assume that `tick16` is a single-cycle pulse with several clock cycles between pulses. They also assume that `nine_bit_mode` and `addr_filt_en` are held steady while a frame is in progress. The stimulus produces a tick every fourth clock cycle and changes the line only in the cycle just after a tick, so the synchronized value is settled before the next tick samples it. Mode and filter settings are changed only while the line is idle, between frames.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_HOLD  = 2'd2
  } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = din;
      end else begin : g_rest
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_voter.sv
module uart_rx_voter #(
  parameter int OVS   = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] phase,
  input  logic             din,
  output logic             vote_bit
);

  localparam int FIRST_ST = OVS/2 - 1;

  logic samp_a_q, samp_a_d;
  logic samp_b_q, samp_b_d;

  always_comb begin
    samp_a_d = samp_a_q;
    samp_b_d = samp_b_q;
    if (tick && phase == CNT_W'(FIRST_ST))     samp_a_d = din;
    if (tick && phase == CNT_W'(FIRST_ST + 1)) samp_b_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a_q <= 1'b1;
      samp_b_q <= 1'b1;
    end else begin
      samp_a_q <= samp_a_d;
      samp_b_q <= samp_b_d;
    end
  end

  assign vote_bit = (samp_a_q & samp_b_q) | (samp_a_q & din) | (samp_b_q & din);

endmodule

// File: rtl/uart_rx_frame_ctl.sv
module uart_rx_frame_ctl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              din,
  input  logic              rx_en,
  input  logic              mode11,
  input  logic              filt_en,
  input  logic              flag_clr,
  input  logic              vote_bit,
  output logic [CNT_W-1:0]  phase,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_extra,
  output logic              rx_flag
);

  localparam int SR_W    = DATA_W + 1;
  localparam int LAST_ST = OVS/2 + 1;

  rx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SR_W-1:0]   sr_q, sr_d;
  logic              smp_q, smp_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              extra_q, extra_d;
  logic              flag_q, flag_d;

  logic vote_vld;
  logic first_bit;
  logic last_bit;
  logic capture;

  assign vote_vld  = tick && (st_q == RX_SHIFT) && (cnt_q == CNT_W'(LAST_ST));
  assign first_bit = (sr_q == '1);
  assign last_bit  = !sr_q[0];
  assign capture   = vote_vld && !first_bit && last_bit && !flag_q &&
                     (!filt_en || vote_bit);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    smp_d   = smp_q;
    byte_d  = byte_q;
    extra_d = extra_q;
    flag_d  = flag_q;

    if (tick) smp_d = din;
    if (flag_clr) flag_d = 1'b0;

    case (st_q)
      RX_IDLE: begin
        if (tick && rx_en && smp_q && !din) begin
          st_d  = RX_SHIFT;
          cnt_d = CNT_W'(1);
          sr_d  = '1;
        end
      end
      RX_SHIFT: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (vote_vld) begin
            if (first_bit && vote_bit) begin
              st_d = RX_IDLE;
            end else begin
              sr_d = {vote_bit, sr_q[SR_W-1:1]};
              if (last_bit) st_d = mode11 ? RX_HOLD : RX_IDLE;
            end
          end
        end
      end
      RX_HOLD: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(LAST_ST)) st_d = RX_IDLE;
        end
      end
      default: st_d = RX_IDLE;
    endcase

    if (capture) begin
      byte_d  = sr_q[SR_W-1:1];
      extra_d = vote_bit;
      flag_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      sr_q    <= '1;
      smp_q   <= 1'b1;
      byte_q  <= '0;
      extra_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sr_q    <= sr_d;
      smp_q   <= smp_d;
      byte_q  <= byte_d;
      extra_q <= extra_d;
      flag_q  <= flag_d;
    end
  end

  assign phase    = cnt_q;
  assign rx_byte  = byte_q;
  assign rx_extra = extra_q;
  assign rx_flag  = flag_q;

  // R2: no frame starts while reception is disabled
  a_r2_arm_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && !rx_en) |=> (st_q == RX_IDLE));

  // R4: a high start vote returns the receiver to idle
  a_r4_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_vld && first_bit && vote_bit) |=> (st_q == RX_IDLE && !$rose(rx_flag)));

  // R6: delivery happens only on a tick edge
  a_r6_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(tick));

  // R7: with the filter on, every delivered extra bit is 1
  a_r7_filter: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_flag) && $past(filt_en)) |-> rx_extra);

  // R7: the byte changes only together with a new delivery
  a_r7_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $rose(rx_flag));

  // R8: the flag stays set until it is cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !flag_clr) |=> rx_flag);

  // R9: the wait after an 11-bit frame never starts a new frame
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_HOLD) |=> (st_q != RX_SHIFT));

endmodule

// File: rtl/mpc_uart_rx.sv
module mpc_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              nine_bit_mode,
  input  logic              addr_filt_en,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_extra,
  output logic              rx_flag
);

  localparam int CNT_W = $clog2(OVS);

  logic             line_s;
  logic             vote_bit;
  logic [CNT_W-1:0] phase;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_line),
    .dout  (line_s)
  );

  uart_rx_voter #(.OVS(OVS), .CNT_W(CNT_W)) u_voter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .phase    (phase),
    .din      (line_s),
    .vote_bit (vote_bit)
  );

  uart_rx_frame_ctl #(.DATA_W(DATA_W), .OVS(OVS), .CNT_W(CNT_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .din      (line_s),
    .rx_en    (rx_en),
    .mode11   (nine_bit_mode),
    .filt_en  (addr_filt_en),
    .flag_clr (flag_clr),
    .vote_bit (vote_bit),
    .phase    (phase),
    .rx_byte  (rx_byte),
    .rx_extra (rx_extra),
    .rx_flag  (rx_flag)
  );

endmodule

// File: tb/mpc_uart_rx_test.sv
`timescale 1ns/1ps
module mpc_uart_rx_test;

  logic       clk;
  logic       rst_n;
  logic       rx_line;
  logic       tick16;
  logic       rx_en;
  logic       nine_bit_mode;
  logic       addr_filt_en;
  logic       flag_clr;
  logic [7:0] rx_byte;
  logic       rx_extra;
  logic       rx_flag;

  mpc_uart_rx uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_line       (rx_line),
    .tick16        (tick16),
    .rx_en         (rx_en),
    .nine_bit_mode (nine_bit_mode),
    .addr_filt_en  (addr_filt_en),
    .flag_clr      (flag_clr),
    .rx_byte       (rx_byte),
    .rx_extra      (rx_extra),
    .rx_flag       (rx_flag)
  );

  typedef struct {
    logic [7:0] data;
    logic       extra;
    int         start_tick;
  } exp_item_t;

  exp_item_t exp_q[$];

  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 0;
  bit         flag_model = 0;
  logic [7:0] last_byte  = 8'h00;
  logic       last_extra = 1'b0;
  logic [1:0] div;
  int         tick_cnt;
  logic       flag_d;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign tick16 = (div == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div      <= 2'd0;
      tick_cnt <= 0;
    end else begin
      div <= div + 2'd1;
      if (tick16) tick_cnt <= tick_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each new delivery (R5, R6)
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_flag && !flag_d) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected delivery", int'(rx_byte), 0);
        end else begin
          exp_item_t it;
          it = exp_q.pop_front();
          check(rx_byte == it.data, "R5", "byte", int'(rx_byte), int'(it.data));
          check(rx_extra == it.extra, "R5", "extra bit", int'(rx_extra), int'(it.extra));
          check(tick_cnt - it.start_tick == 154, "R6", "ticks to flag",
                tick_cnt - it.start_tick, 154);
        end
      end
      flag_d = rx_flag;
    end else begin
      flag_d = 1'b0;
    end
  end

  task automatic tick_edge();
    do @(negedge clk); while (tick16 !== 1'b1);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) tick_edge();
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    flag_model = 0;
  endtask

  // Driver: sends one frame and pushes the expected delivery
  task automatic send_frame(input logic [7:0] d, input logic x, input int tail,
                            input int glitch_bit, input bit seen);
    bit deliver;
    deliver = seen && rx_en && !flag_model && (!addr_filt_en || x);
    tick_edge();
    rx_line = 1'b0;
    if (deliver) begin
      exp_q.push_back('{data: d, extra: x, start_tick: tick_cnt});
      flag_model = 1;
      last_byte  = d;
      last_extra = x;
    end
    ticks(16);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i];
      if (i == glitch_bit) begin
        ticks(7);
        rx_line = ~d[i];
        ticks(1);
        rx_line = d[i];
        ticks(8);
      end else begin
        ticks(16);
      end
    end
    rx_line = x;
    if (nine_bit_mode) begin
      ticks(16);
      rx_line = 1'b1;
    end
    ticks(tail);
    rx_line = 1'b1;
  endtask

  task automatic settle_and_check(input string req);
    ticks(24);
    check(rx_flag == flag_model, req, "flag", int'(rx_flag), int'(flag_model));
    check(rx_byte == last_byte, req, "byte held", int'(rx_byte), int'(last_byte));
    check(rx_extra == last_extra, req, "extra held", int'(rx_extra), int'(last_extra));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n         = 1'b0;
    rx_line       = 1'b1;
    rx_en         = 1'b1;
    nine_bit_mode = 1'b0;
    addr_filt_en  = 1'b0;
    flag_clr      = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset values
    check(rx_flag == 1'b0, "R1", "flag", int'(rx_flag), 0);
    check(rx_byte == 8'h00, "R1", "byte", int'(rx_byte), 0);
    check(rx_extra == 1'b0, "R1", "extra", int'(rx_extra), 0);
    rst_n = 1'b1;
    ticks(20);

    // R5 R6: plain 10-bit frame
    send_frame(8'hA5, 1'b1, 16, -1, 1);
    settle_and_check("R5");
    clear_flag();

    // R3: one corrupted sample inside data bit 3
    send_frame(8'h3C, 1'b1, 16, 3, 1);
    settle_and_check("R3");
    clear_flag();

    // R4: short low pulse is rejected as a start bit
    tick_edge();
    rx_line = 1'b0;
    ticks(4);
    rx_line = 1'b1;
    ticks(30);
    settle_and_check("R4");

    // R2: reception disabled
    rx_en = 1'b0;
    send_frame(8'h11, 1'b1, 16, -1, 1);
    settle_and_check("R2");
    rx_en = 1'b1;

    // R5: 11-bit frame with ninth bit 0, filter off
    nine_bit_mode = 1'b1;
    send_frame(8'h5A, 1'b0, 16, -1, 1);
    settle_and_check("R5");
    clear_flag();

    // R7: filter drops a data frame, then passes an address frame
    addr_filt_en = 1'b1;
    send_frame(8'h77, 1'b0, 16, -1, 1);
    settle_and_check("R7");
    send_frame(8'hC3, 1'b1, 16, -1, 1);
    settle_and_check("R7");

    // R8: flag left set, next frame is dropped and the flag holds
    addr_filt_en  = 1'b0;
    nine_bit_mode = 1'b0;
    send_frame(8'h99, 1'b1, 16, -1, 1);
    settle_and_check("R8");
    clear_flag();
    @(negedge clk);
    check(rx_flag == 1'b0, "R8", "flag after clear", int'(rx_flag), 0);

    // R7: 10-bit frame with stop bit 0 under the filter
    addr_filt_en = 1'b1;
    send_frame(8'h42, 1'b0, 16, -1, 1);
    settle_and_check("R7");
    send_frame(8'h42, 1'b1, 16, -1, 1);
    settle_and_check("R7");
    clear_flag();
    addr_filt_en = 1'b0;

    // R9: 10-bit frames back to back are both received
    send_frame(8'h81, 1'b1, 16, -1, 1);
    clear_flag();
    send_frame(8'h66, 1'b1, 16, -1, 1);
    settle_and_check("R9");
    clear_flag();

    // R9: in 11-bit mode a start edge inside the wait window is missed
    nine_bit_mode = 1'b1;
    send_frame(8'h81, 1'b1, 6, -1, 1);
    clear_flag();
    send_frame(8'h00, 1'b0, 16, -1, 0);
    settle_and_check("R9");

    check(exp_q.size() == 0, "R7", "pending deliveries", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule